// File: doc/BRIEF.md
# Dual-Sensor Serial Thermometer Host Bridge

This block sits on a simple register bus and lets a processor drive two three-wire digital temperature sensors in lockstep. Software toggles a serial-clock state through a control register, clocks an 8-bit command into the sensors one bit per write through a data-write register, and then collects the answer one bit per read through a data-read register. Each read returns a word in which bit i is the current bit of sensor i, so both sensors are read in parallel.

The bridge holds the command word, a data word, the two bit positions and each sensor's configuration and temperature values. It decodes the completed command. A start-conversion command clears the engine. The two read commands arm bit-serial readback. Any other code raises a one-cycle unknown-command strobe. Once the last bit of the selected field has been read, the engine clears itself, so the next command can be sent at once. Conversion timing, thermostat trip logic and analog sensing are not modelled.

Register addresses: 0 = control, 1 = data write, 2 = data read, 3 = unused.

Top module: `thermo_bridge`

## Requirements
- R1: After reset, rd_data and unknown_cmd are zero, the clock-low flag is clear, and no read command is armed.
- R2: A control write of 0x01 clears the command word, the command bit position, the data word and the data bit position. A control write of 0x02 sets the clock-low flag and 0x03 clears it. Other control values have no effect.
- R3: While the clock-low flag is clear, a data-port write of any value other than 0x80 changes no state.
- R4: A data-port write of 0x80 sets the data bit position to zero and leaves the command word and its position as they were, whatever the clock-low flag is.
- R5: While the flag is set, the first 8 data-port writes fill the command LSB first. A value of 0x01 gives a 1 bit and any other value gives a 0 bit.
- R6: Completing command 0xEE clears the whole engine, so no read is armed and a new command can follow at once.
- R7: Completing 0xAA (temperature) or 0xAC (configuration) arms readback. Completing any other code pulses unknown_cmd in the cycle after the completing write.
- R8: Flag-qualified data writes after a complete command shift into the data word LSB first and advance the data bit position, which saturates at 16. This moves the readback position.
- R9: A read at address 2 while armed makes rd_data bit i equal bit[position] of sensor i's selected field (9-bit temperature or 8-bit configuration) in the next cycle, with zero above bit 1. The position then advances. rd_data is zero in every other cycle.
- R10: A read whose position is the field's last bit or beyond clears the engine. Such a read returns zero when the position is beyond the field.
- R11: A read at address 2 while nothing is armed returns zero and pulses unknown_cmd for one cycle.
- R12: Both sensors hold temperature 44 (22 degrees in half-degree units) and configuration 0x02, where bit 1 marks CPU mode.
- R13: In a cycle with wr_en high, rd_en is ignored. Reads of addresses 0, 1 and 3 return zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result, valid the cycle after a read |
| unknown_cmd | output | 1 | One-cycle strobe for an unknown command or an unarmed read |

## Verification
The assertions check on every cycle that rd_data has no bits above the sensor count and is nonzero only right after a data-port read. They also check that control writes clear the positions and set or clear the flag, that gated data writes leave both positions stable, that the rewind code zeroes only the data position, and that the data position stays within its bound. Bit ordering of the command and the returned fields, the automatic clear after the last bit, the start-conversion clear and the effect of data writes on the readback position can only be shown by the bench's scenarios against its reference model.

// File: rtl/thermo_bridge_pkg.sv
package thermo_bridge_pkg;
  localparam int ADDR_W = 2;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_WDATA = 2'd1;
  localparam logic [ADDR_W-1:0] REG_RDATA = 2'd2;

  localparam logic [BYTE_W-1:0] CTL_CLEAR = 8'h01;
  localparam logic [BYTE_W-1:0] CTL_LOW   = 8'h02;
  localparam logic [BYTE_W-1:0] CTL_HIGH  = 8'h03;

  localparam logic [BYTE_W-1:0] DAT_ONE   = 8'h01;
  localparam logic [BYTE_W-1:0] DAT_REWIND = 8'h80;

  localparam logic [BYTE_W-1:0] OP_RD_TEMP = 8'hAA;
  localparam logic [BYTE_W-1:0] OP_RD_CFG  = 8'hAC;
  localparam logic [BYTE_W-1:0] OP_CONVERT = 8'hEE;

  typedef enum logic [1:0] {
    RB_NONE = 2'd0,
    RB_CFG  = 2'd1,
    RB_TEMP = 2'd2
  } rb_kind_e;
endpackage

// File: rtl/thermo_clk_flag.sv
module thermo_clk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_low,
  input  logic set_high,
  output logic clk_low
);
  logic low_q, low_d;

  always_comb begin
    low_d = low_q;
    if (set_low)       low_d = 1'b1;
    else if (set_high) low_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= low_d;
  end

  assign clk_low = low_q;
endmodule

// File: rtl/thermo_cmd_shift.sv
module thermo_cmd_shift #(
  parameter int CMD_W = 8,
  localparam int POS_W = $clog2(CMD_W + 1),
  localparam int IDX_W = $clog2(CMD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [CMD_W-1:0] cmd_q,
  output logic [POS_W-1:0] pos_q,
  output logic             done,
  output logic             fin,
  output logic [CMD_W-1:0] fin_code
);
  logic [CMD_W-1:0] cmd_d, cmd_shifted;
  logic [POS_W-1:0] pos_d;
  logic             take;

  assign done = (pos_q == POS_W'(CMD_W));
  assign take = shift_en && !done;

  always_comb begin
    cmd_shifted = cmd_q;
    if (!done && bit_in) cmd_shifted[pos_q[IDX_W-1:0]] = 1'b1;
  end

  assign fin      = take && (pos_q == POS_W'(CMD_W - 1));
  assign fin_code = cmd_shifted;

  always_comb begin
    cmd_d = cmd_q;
    pos_d = pos_q;
    if (clr) begin
      cmd_d = '0;
      pos_d = '0;
    end else if (take) begin
      cmd_d = cmd_shifted;
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      pos_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      pos_q <= pos_d;
    end
  end
endmodule

// File: rtl/thermo_readback.sv
module thermo_readback
  import thermo_bridge_pkg::*;
#(
  parameter int NUM_SENSORS = 2,
  parameter int DATA_W      = 16,
  parameter int CFG_W       = 8,
  parameter int TEMP_W      = 9,
  parameter logic [CFG_W-1:0]  CFG_INIT  = 8'h02,
  parameter logic [TEMP_W-1:0] TEMP_INIT = 9'd44,
  localparam int POS_W   = $clog2(DATA_W + 1),
  localparam int IDX_W   = $clog2(DATA_W),
  localparam int FIELD_W = (TEMP_W > CFG_W) ? TEMP_W : CFG_W,
  localparam int LEN_W   = POS_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   rewind,
  input  logic                   wr_shift,
  input  logic                   bit_in,
  input  logic                   rd_step,
  input  rb_kind_e               kind,
  output logic [POS_W-1:0]       pos_q,
  output logic [NUM_SENSORS-1:0] bits,
  output logic                   last
);
  localparam logic [LEN_W-1:0] CFG_LEN  = LEN_W'(CFG_W);
  localparam logic [LEN_W-1:0] TEMP_LEN = LEN_W'(TEMP_W);
  localparam logic [POS_W-1:0] POS_MAX  = POS_W'(DATA_W);

  logic [DATA_W-1:0] data_q, data_d;
  logic [POS_W-1:0]  pos_d;
  logic [LEN_W-1:0]  field_len;
  logic              room;

  assign room      = (pos_q < POS_MAX);
  assign field_len = (kind == RB_TEMP) ? TEMP_LEN : CFG_LEN;
  assign last      = ({1'b0, pos_q} + LEN_W'(1)) >= field_len;

  // one bit lane per sensor
  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_lane
    logic [FIELD_W-1:0] cfg_field, temp_field, sel_field;
    logic               lane_bit;

    assign cfg_field  = FIELD_W'(CFG_INIT);
    assign temp_field = FIELD_W'(TEMP_INIT);
    assign sel_field  = (kind == RB_TEMP) ? temp_field : cfg_field;

    always_comb begin
      lane_bit = 1'b0;
      for (int k = 0; k < FIELD_W; k++) begin
        if (pos_q == POS_W'(k)) lane_bit = sel_field[k];
      end
    end

    assign bits[g] = lane_bit;
  end

  always_comb begin
    data_d = data_q;
    pos_d  = pos_q;
    if (clr) begin
      data_d = '0;
      pos_d  = '0;
    end else if (rewind) begin
      pos_d = '0;
    end else if (wr_shift) begin
      if (room) begin
        if (bit_in) data_d[pos_q[IDX_W-1:0]] = 1'b1;
        pos_d = pos_q + 1'b1;
      end
    end else if (rd_step) begin
      if (room) pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pos_q  <= '0;
    end else begin
      data_q <= data_d;
      pos_q  <= pos_d;
    end
  end
endmodule

// File: rtl/thermo_bridge.sv
module thermo_bridge
  import thermo_bridge_pkg::*;
#(
  parameter int NUM_SENSORS = 2,
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 16,
  parameter int RD_W        = 8,
  parameter int CFG_W       = 8,
  parameter int TEMP_W      = 9,
  parameter logic [CFG_W-1:0]  CFG_INIT  = 8'h02,
  parameter logic [TEMP_W-1:0] TEMP_INIT = 9'd44,
  localparam int CPOS_W = $clog2(CMD_W + 1),
  localparam int DPOS_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [RD_W-1:0]   rd_data,
  output logic              unknown_cmd
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic wr_ctrl, wr_dat, rd_dat;
  logic ctl_clear, rewind_code, accept;
  logic clk_low;
  logic [CMD_W-1:0]  cmd_q, fin_code;
  logic [CPOS_W-1:0] cmd_pos;
  logic              cmd_done, cmd_fin;
  logic [DPOS_W-1:0] data_pos;
  logic [NUM_SENSORS-1:0] lane_bits;
  logic              rb_last;
  rb_kind_e          kind;
  logic              armed, rd_step;
  logic              fin_start, fin_unknown, engine_clr;
  logic [RD_W-1:0]   rd_data_d, rd_data_q;
  logic              unk_d, unk_q;

  assign wr_ctrl     = wr_en && (addr == REG_CTRL);
  assign wr_dat      = wr_en && (addr == REG_WDATA);
  assign rd_dat      = rd_en && !wr_en && (addr == REG_RDATA);
  assign ctl_clear   = wr_ctrl && (wdata == CTL_CLEAR);
  assign rewind_code = wr_dat && (wdata == DAT_REWIND);
  assign accept      = wr_dat && !rewind_code && clk_low;

  thermo_clk_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_low  (wr_ctrl && (wdata == CTL_LOW)),
    .set_high (wr_ctrl && (wdata == CTL_HIGH)),
    .clk_low  (clk_low)
  );

  thermo_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (engine_clr),
    .shift_en (accept),
    .bit_in   (wdata == DAT_ONE),
    .cmd_q    (cmd_q),
    .pos_q    (cmd_pos),
    .done     (cmd_done),
    .fin      (cmd_fin),
    .fin_code (fin_code)
  );

  always_comb begin
    kind = RB_NONE;
    if (cmd_done) begin
      if (cmd_q == CMD_W'(OP_RD_TEMP))     kind = RB_TEMP;
      else if (cmd_q == CMD_W'(OP_RD_CFG)) kind = RB_CFG;
    end
  end

  assign armed   = (kind != RB_NONE);
  assign rd_step = rd_dat && armed;

  thermo_readback #(
    .NUM_SENSORS (NUM_SENSORS),
    .DATA_W      (DATA_W),
    .CFG_W       (CFG_W),
    .TEMP_W      (TEMP_W),
    .CFG_INIT    (CFG_INIT),
    .TEMP_INIT   (TEMP_INIT)
  ) u_rb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (engine_clr),
    .rewind   (rewind_code),
    .wr_shift (accept && cmd_done),
    .bit_in   (wdata == DAT_ONE),
    .rd_step  (rd_step),
    .kind     (kind),
    .pos_q    (data_pos),
    .bits     (lane_bits),
    .last     (rb_last)
  );

  assign fin_start   = cmd_fin && (fin_code == CMD_W'(OP_CONVERT));
  assign fin_unknown = cmd_fin && (fin_code != CMD_W'(OP_CONVERT))
                               && (fin_code != CMD_W'(OP_RD_TEMP))
                               && (fin_code != CMD_W'(OP_RD_CFG));
  assign engine_clr  = ctl_clear || fin_start || (rd_step && rb_last);

  assign rd_data_d = rd_step ? RD_W'(lane_bits) : '0;
  assign unk_d     = fin_unknown || (rd_dat && !armed);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data_q <= '0;
      unk_q     <= 1'b0;
    end else begin
      rd_data_q <= rd_data_d;
      unk_q     <= unk_d;
    end
  end

  assign rd_data     = rd_data_q;
  assign unknown_cmd = unk_q;
endmodule

// File: rtl/thermo_bridge_chk.sv
module thermo_bridge_chk #(
  parameter int NUM_SENSORS = 2,
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 16,
  parameter int RD_W        = 8,
  localparam int CPOS_W = $clog2(CMD_W + 1),
  localparam int DPOS_W = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [7:0]        wdata,
  input logic [RD_W-1:0]   rd_data,
  input logic              unknown_cmd,
  input logic              clk_low,
  input logic [CPOS_W-1:0] cmd_pos,
  input logic [DPOS_W-1:0] data_pos
);
  // R9
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data >> NUM_SENSORS) == '0);

  // R9
  rd_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data != '0) |-> $past(rd_en && !wr_en && addr == 2'd2));

  // R2
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 2'd0 && wdata == 8'h01) |=> (cmd_pos == '0 && data_pos == '0));

  // R2
  flag_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 2'd0 && wdata == 8'h02) |=> clk_low);

  // R2
  flag_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 2'd0 && wdata == 8'h03) |=> !clk_low);

  // R3
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 2'd1 && wdata != 8'h80 && !clk_low)
      |=> ($stable(cmd_pos) && $stable(data_pos)));

  // R4
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 2'd1 && wdata == 8'h80) |=> (data_pos == '0 && $stable(cmd_pos)));

  // R8
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_pos <= DPOS_W'(DATA_W));

  // R11
  unk_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unknown_cmd |-> $past(wr_en || rd_en));
endmodule

bind thermo_bridge thermo_bridge_chk #(
  .NUM_SENSORS (NUM_SENSORS),
  .CMD_W       (CMD_W),
  .DATA_W      (DATA_W),
  .RD_W        (RD_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .rd_data     (rd_data),
  .unknown_cmd (unknown_cmd),
  .clk_low     (clk_low),
  .cmd_pos     (cmd_pos),
  .data_pos    (data_pos)
);

// File: tb/thermo_bridge_bench.sv
module thermo_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rd_data;
  logic       unknown_cmd;

  int n_chk  = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_cmd, m_cpos, m_data, m_dpos;
  bit m_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_bridge u_thermo_bridge (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .unknown_cmd(unknown_cmd)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_clear();
    m_cmd = 0; m_cpos = 0; m_data = 0; m_dpos = 0;
  endtask

  function automatic bit is_read_op(int c);
    return (c == 'hAA) || (c == 'hAC);
  endfunction

  // one bus cycle: drive at negedge, predict, compare at next negedge
  task automatic step(bit w, bit r, int a, int d, string req);
    int e_rd = 0;
    bit e_unk = 0;
    wr_en = w; rd_en = r; addr = 2'(a); wdata = 8'(d);
    if (w) begin
      if (a == 0) begin
        if (d == 1) m_clear();
        else if (d == 2) m_low = 1;
        else if (d == 3) m_low = 0;
      end else if (a == 1) begin
        if (d == 'h80) m_dpos = 0;
        else if (m_low) begin
          if (m_cpos < 8) begin
            if (d == 1) m_cmd = m_cmd | (1 << m_cpos);
            m_cpos++;
            if (m_cpos == 8) begin
              if (m_cmd == 'hEE) m_clear();
              else if (!is_read_op(m_cmd)) e_unk = 1;
            end
          end else if (m_dpos < 16) begin
            if (d == 1) m_data = m_data | (1 << m_dpos);
            m_dpos++;
          end
        end
      end
    end else if (r && a == 2) begin
      if (m_cpos == 8 && is_read_op(m_cmd)) begin
        int len = (m_cmd == 'hAA) ? 9 : 8;
        int val = (m_cmd == 'hAA) ? 44 : 2;
        int b = (m_dpos < len) ? ((val >> m_dpos) & 1) : 0;
        e_rd = b ? 3 : 0;
        m_dpos++;
        if (m_dpos >= len) m_clear();
      end else e_unk = 1;
    end
    @(negedge clk);
    check(req, "rd_data", int'(rd_data), e_rd);
    check(req, "unknown_cmd", int'(unknown_cmd), int'(e_unk));
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic send_cmd(int code, string req);
    for (int k = 0; k < 8; k++) step(1, 0, 1, ((code >> k) & 1) ? 1 : 0, req);
  endtask

  task automatic reads(int n, string req);
    for (int k = 0; k < n; k++) step(0, 1, 2, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    m_clear(); m_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state, R11 unarmed read
    step(0, 0, 0, 0, "R1");
    reads(1, "R11");

    // R3 flag clear: command bits ignored, still unarmed
    send_cmd('hAA, "R3");
    reads(1, "R3");

    // R5 R7 R9 R12 temperature readback, R10 auto clear
    step(1, 0, 0, 2, "R2");
    send_cmd('hAA, "R5");
    reads(9, "R9");
    reads(1, "R10");

    // configuration readback, R12 CPU-mode bit
    send_cmd('hAC, "R12");
    reads(8, "R12");
    reads(1, "R10");

    // R4 rewind keeps command; R8 data writes move position
    send_cmd('hAA, "R7");
    reads(3, "R9");
    step(1, 0, 1, 'h80, "R4");
    reads(3, "R4");
    step(1, 0, 1, 1, "R8");
    step(1, 0, 1, 0, "R8");
    reads(5, "R8");

    // R6 start conversion clears; new command follows at once
    send_cmd('hEE, "R6");
    reads(1, "R6");
    send_cmd('hAA, "R6");
    reads(9, "R6");

    // R7 unknown code, then R2 control clear re-enables commands
    send_cmd('h55, "R7");
    reads(1, "R11");
    step(1, 0, 0, 1, "R2");
    send_cmd('hAC, "R2");

    // R13 write wins over read; reads elsewhere inert
    step(1, 1, 2, 0, "R13");
    step(0, 1, 0, 0, "R13");
    step(0, 1, 3, 0, "R13");
    reads(2, "R13");
    step(1, 0, 0, 7, "R2");
    reads(6, "R2");

    // R8 saturation beyond field, R10 clear on out-of-field read
    send_cmd('hAA, "R8");
    for (int k = 0; k < 20; k++) step(1, 0, 1, 1, "R8");
    reads(2, "R10");

    // R2 clock high gates again
    step(1, 0, 0, 3, "R2");
    send_cmd('hAC, "R3");
    reads(1, "R3");

    step(0, 0, 0, 0, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule